// File: doc/BRIEF.md
# Programmable Watchdog Timer with Timeout Steering

This block supervises a processor through a single 8-bit control byte. The byte picks a coarse time unit, a 5-bit count of those units, and where a timeout goes. While the count is nonzero the block advances on a base tick enable at 1/16 s per tick. If the processor neither rewrites the control byte nor toggles the kick pin before the programmed span runs out, the block sets a sticky timeout flag. It then either holds an active-low interrupt line or fires a fixed-length active-low reset pulse.

The steered-to-reset path clears the control byte and gives a one-cycle strobe. Neighbouring logic uses that strobe to drop its own enables, such as the frequency-test, alarm-interrupt and backup-alarm bits. The kick pin is asynchronous and is synchronized inside the block. A change in either direction counts as a kick.

Top module: `wdt_steer`

## Requirements
- R1: After reset the control byte reads 0x00, the flag reads 0, `irq_no` and `rst_no` are 1 and `clr_en_o` is 0.
- R2: Control byte layout: bit 7 steers, bits 6..2 hold the multiplier M and bits 1..0 the unit code U. Units in base ticks are U=0:1, U=1:4, U=2:16 and U=3:64. The flag sets on the clock edge that samples the (M × unit)-th base tick after the last kick.
- R3: Any write to the control byte restarts the timeout count from zero.
- R4: A rising or a falling change on `wdi_i` restarts the count within four clock cycles of the change.
- R5: With M = 0, including after a write of 0x00, no timeout occurs however many ticks arrive.
- R6: The flag stays set until a flag-read strobe clears it. A timeout in the same cycle as the read leaves it set.
- R7: A timeout with bit 7 = 0 drives `irq_no` low from that edge. It stays low through any write except 0x00, and a write of 0x00 releases it.
- R8: A timeout with bit 7 = 1 drives `rst_no` low for exactly TREC_CYC clock cycles, starting at the timeout edge, and leaves `irq_no` high.
- R9: A timeout with bit 7 = 1 clears the control byte to 0x00 and pulses `clr_en_o` high for one cycle.
- R10: A control write in the same cycle as the final tick wins: no timeout occurs and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base tick enable, one per 1/16 s |
| reg_we_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| wdi_i | input | 1 | Asynchronous kick pin, either edge |
| flag_rd_i | input | 1 | Flag read strobe, clears the flag |
| wd_reg_o | output | 8 | Current control byte |
| wdf_o | output | 1 | Sticky timeout flag |
| irq_no | output | 1 | Interrupt, active low |
| rst_no | output | 1 | Reset pulse, active low |
| clr_en_o | output | 1 | One-cycle strobe to clear neighbour enables |

## Verification
The hardest case to reach is a control write that arrives in the very cycle the final tick would expire the count. The stimulus stops the tick one short of the span. It then raises the tick and the write strobe together for a single cycle, and counts a full fresh span afterwards. The longest span, 31 × 64 ticks, is reached by holding the tick enable high continuously so that it costs only about two thousand cycles. Kicks from the pin are checked in both directions, with idle cycles that cover the synchronizer delay.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int PRE_W  = 2 * ((1 << RES_W) - 1);

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wd_cfg_t;

  // last prescaler value for a unit code: 4^code - 1
  function automatic logic [PRE_W-1:0] res_last(input logic [RES_W-1:0] code);
    int unsigned span;
    span = 32'd1 << (2 * int'(code));
    return PRE_W'(span - 32'd1);
  endfunction
endpackage

// File: rtl/wdt_kick_det.sv
module wdt_kick_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    kick_i,
  input  wd_cfg_t cfg_i,
  output logic    expire_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [MULT_W-1:0] step_q;
  logic [PRE_W-1:0]  pre_last;
  logic [MULT_W-1:0] step_last;
  logic              active, pre_wrap, all_wrap;

  assign active    = cfg_i.mult != '0;
  assign pre_last  = res_last(cfg_i.res);
  assign step_last = cfg_i.mult - 1'b1;
  assign pre_wrap  = tick_i && active && (pre_q == pre_last);
  assign all_wrap  = pre_wrap && (step_q == step_last);
  assign expire_o  = all_wrap && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      step_q <= '0;
    end else if (kick_i || !active) begin
      pre_q  <= '0;
      step_q <= '0;
    end else if (tick_i) begin
      if (pre_wrap) begin
        pre_q  <= '0;
        step_q <= all_wrap ? '0 : step_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp #(
  parameter int TREC_CYC = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic steer_i,
  input  logic flag_rd_i,
  input  logic release_i,
  output logic wdf_o,
  output logic irq_no,
  output logic rst_no,
  output logic clr_en_o
);
  localparam int CW = $clog2(TREC_CYC + 1);

  logic [CW-1:0] pulse_q;
  logic          wdf_q, irq_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdf_q   <= 1'b0;
      irq_q   <= 1'b0;
      clr_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (expire_i)       wdf_q <= 1'b1;
      else if (flag_rd_i) wdf_q <= 1'b0;

      if (expire_i && !steer_i) irq_q <= 1'b1;
      else if (release_i)       irq_q <= 1'b0;

      clr_q <= expire_i && steer_i;

      if (expire_i && steer_i) pulse_q <= CW'(TREC_CYC);
      else if (pulse_q != '0)  pulse_q <= pulse_q - 1'b1;
    end
  end

  assign wdf_o    = wdf_q;
  assign irq_no   = ~irq_q;
  assign rst_no   = (pulse_q == '0);
  assign clr_en_o = clr_q;
endmodule

// File: rtl/wdt_steer.sv
module wdt_steer
  import wdt_pkg::*;
#(
  parameter int TREC_CYC    = 40000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       wdi_i,
  input  logic       flag_rd_i,
  output logic [7:0] wd_reg_o,
  output logic       wdf_o,
  output logic       irq_no,
  output logic       rst_no,
  output logic       clr_en_o
);
  wd_cfg_t cfg_q;
  logic    pin_edge, kick, expire, release_w;

  wdt_kick_det #(.STAGES(SYNC_STAGES)) u_kick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (wdi_i),
    .edge_o (pin_edge)
  );

  assign kick      = reg_we_i || pin_edge;
  assign release_w = reg_we_i && (reg_wdata_i == 8'h00);

  wdt_timer u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .kick_i   (kick),
    .cfg_i    (cfg_q),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cfg_q <= '0;
    else if (expire && cfg_q.steer) cfg_q <= '0;
    else if (reg_we_i)              cfg_q <= wd_cfg_t'(reg_wdata_i);
  end

  wdt_resp #(.TREC_CYC(TREC_CYC)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .steer_i   (cfg_q.steer),
    .flag_rd_i (flag_rd_i),
    .release_i (release_w),
    .wdf_o     (wdf_o),
    .irq_no    (irq_no),
    .rst_no    (rst_no),
    .clr_en_o  (clr_en_o)
  );

  assign wd_reg_o = cfg_q;
endmodule

// File: rtl/wdt_steer_chk.sv
module wdt_steer_chk #(
  parameter int TREC_CYC = 40000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic       flag_rd_i,
  input logic       expire_i,
  input logic [7:0] wd_reg_o,
  input logic       wdf_o,
  input logic       irq_no,
  input logic       rst_no
);
  int unsigned low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_run <= 0;
    else if (!rst_no) low_run <= low_run + 1;
    else             low_run <= 0;
  end

  p_mult_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_reg_o[6:2] == 5'd0) |-> !expire_i);

  p_write_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> !expire_i);

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdf_o && !flag_rd_i) |=> wdf_o);

  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !expire_i) |=> !wdf_o);

  p_irq_steer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !wd_reg_o[7]) |=> !irq_no);

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !(reg_we_i && reg_wdata_i == 8'h00)) |=> !irq_no);

  p_rst_steer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && wd_reg_o[7]) |=> (!rst_no && wd_reg_o == 8'h00));

  p_pulse_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (low_run >= TREC_CYC));
endmodule

bind wdt_steer wdt_steer_chk #(.TREC_CYC(TREC_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .flag_rd_i   (flag_rd_i),
  .expire_i    (expire),
  .wd_reg_o    (wd_reg_o),
  .wdf_o       (wdf_o),
  .irq_no      (irq_no),
  .rst_no      (rst_no)
);

// File: tb/wdt_steer_test.sv
module wdt_steer_test;
  localparam int TREC = 20;
  localparam logic [11:0] M_ALL = 12'hFFF, M_REG = 12'hFF0, M_WDF = 12'h008,
                          M_IRQ = 12'h004, M_RST = 12'h002, M_CLR = 12'h001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, we = 1'b0, wdi = 1'b0, frd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] wd_reg;
  logic wdf, irq_n, rst_pn, clr_en;

  wdt_steer #(.TREC_CYC(TREC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_wdata_i(wdata), .wdi_i(wdi), .flag_rd_i(frd),
    .wd_reg_o(wd_reg), .wdf_o(wdf), .irq_no(irq_n), .rst_no(rst_pn),
    .clr_en_o(clr_en)
  );

  always #2 clk = ~clk;

  typedef struct {
    string       req;
    logic [11:0] exp;
    logic [11:0] mask;
  } item_t;

  item_t q[$];
  event  smp_ev;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  // monitor: pop expected items and compare against the live outputs
  initial forever begin
    @(smp_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [11:0] act;
      it  = q.pop_front();
      act = {wd_reg, wdf, irq_n, rst_pn, clr_en};
      checks++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: actual=%03h expected=%03h mask=%03h",
                 it.req, act, it.exp, it.mask);
      end
    end
  end

  task automatic expect_out(input string req, input logic [11:0] exp,
                            input logic [11:0] mask);
    item_t it;
    it.req = req; it.exp = exp; it.mask = mask;
    q.push_back(it);
    -> smp_ev;
    #0;
  endtask

  task automatic exp_wdf(input string req, input logic v);
    expect_out(req, {8'h00, v, 3'b000}, M_WDF);
  endtask

  task automatic exp_irq(input string req, input logic v);
    expect_out(req, {9'h000, v, 2'b00}, M_IRQ);
  endtask

  task automatic exp_rst(input string req, input logic v);
    expect_out(req, {10'h000, v, 1'b0}, M_RST);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdflag();
    frd = 1'b1;
    @(negedge clk);
    frd = 1'b0;
  endtask

  task automatic tidy();
    wr(8'h00);
    rdflag();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_out("R1 reset state", {8'h00, 1'b0, 1'b1, 1'b1, 1'b0}, M_ALL);

    // R2/R7: M=3, unit 1 tick
    wr(8'h0C);
    ticks(2);
    exp_wdf("R2 no flag before span", 1'b0);
    exp_irq("R7 irq idle before span", 1'b1);
    ticks(1);
    exp_wdf("R2 flag at span end", 1'b1);
    exp_irq("R7 irq low on timeout", 1'b0);
    wr(8'h0C);
    exp_irq("R7 nonzero write keeps irq", 1'b0);
    expect_out("R3 register rewritten", {8'h0C, 4'h0}, M_REG);
    rdflag();
    exp_wdf("R6 read clears flag", 1'b0);
    wr(8'h00);
    exp_irq("R7 write 0x00 releases irq", 1'b1);
    rdflag();

    // R2: M=2, unit 4 ticks
    wr(8'h09);
    ticks(7);
    exp_wdf("R2 unit4 one short", 1'b0);
    ticks(1);
    exp_wdf("R2 unit4 span end", 1'b1);
    tidy();

    // R2: longest span M=31, unit 64
    wr(8'h7F);
    ticks(1983);
    exp_wdf("R2 longest one short", 1'b0);
    ticks(1);
    exp_wdf("R2 longest span end", 1'b1);
    tidy();

    // R3: rewrite restarts
    wr(8'h0C);
    ticks(2);
    wr(8'h0C);
    ticks(2);
    exp_wdf("R3 rewrite restarted count", 1'b0);
    ticks(1);
    exp_wdf("R3 flag after fresh span", 1'b1);
    tidy();

    // R4: rising then falling pin change
    wr(8'h0C);
    ticks(2);
    wdi = 1'b1;
    cyc(4);
    ticks(2);
    exp_wdf("R4 rising edge kick", 1'b0);
    ticks(1);
    exp_wdf("R4 flag after rising kick span", 1'b1);
    tidy();
    wr(8'h0C);
    ticks(2);
    wdi = 1'b0;
    cyc(4);
    ticks(2);
    exp_wdf("R4 falling edge kick", 1'b0);
    ticks(1);
    exp_wdf("R4 flag after falling kick span", 1'b1);
    tidy();

    // R5: multiplier zero
    wr(8'h03);
    ticks(200);
    exp_wdf("R5 M=0 never expires", 1'b0);
    exp_irq("R5 M=0 irq idle", 1'b1);
    wr(8'h0C);
    ticks(2);
    wr(8'h00);
    ticks(100);
    exp_wdf("R5 write 0x00 disables", 1'b0);

    // R10: write coincides with final tick
    wr(8'h0C);
    ticks(2);
    tick = 1'b1; we = 1'b1; wdata = 8'h0C;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
    exp_wdf("R10 write beats final tick", 1'b0);
    ticks(2);
    exp_wdf("R10 count restarted", 1'b0);
    ticks(1);
    exp_wdf("R10 flag after fresh span", 1'b1);
    tidy();

    // R6: timeout and read together
    wr(8'h04);
    tick = 1'b1; frd = 1'b1;
    @(negedge clk);
    tick = 1'b0; frd = 1'b0;
    exp_wdf("R6 timeout wins over read", 1'b1);
    rdflag();
    exp_wdf("R6 later read clears", 1'b0);
    wr(8'h00);

    // R8/R9: steer to reset, M=1 unit 1
    wr(8'h84);
    ticks(1);
    expect_out("R9 reset steer clears byte and strobes",
               {8'h00, 1'b1, 1'b1, 1'b0, 1'b1}, M_ALL);
    cyc(1);
    expect_out("R9 strobe lasts one cycle", {11'h000, 1'b0}, M_CLR);
    exp_rst("R8 pulse still low", 1'b0);
    cyc(18);
    exp_rst("R8 pulse low at last cycle", 1'b0);
    exp_irq("R8 irq untouched", 1'b1);
    cyc(1);
    exp_rst("R8 pulse ends after TREC", 1'b1);
    ticks(20);
    exp_rst("R9 cleared byte stays idle", 1'b1);
    rdflag();

    cyc(2);
    -> smp_ev;
    #1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule